// File: doc/BRIEF.md
# Ring-Oscillator Response Evaluator

This block turns a pair of free-running ring-oscillator lines into one response bit. A challenge word is shifted in serially from a test-access shift path on its own shift clock. The word is always visible in parallel. Its low nibble names the oscillator for counter A. Its high nibble names the oscillator for counter B.

A start request locks the challenge into the system clock domain and clears both counters. It then opens a measurement window whose length, in system clock cycles, is given on an input. During the window, rising edges of the two chosen lines are counted. The oscillator lines never clock anything. Every line is brought into the single system clock through a two-flop synchroniser, and its detected rising edge acts as a count enable.

When the window closes, a one-cycle done pulse marks that both counts and the response are final. The response is 1 when count A is larger than count B. All three values hold until the next start.

Top module: `ro_puf_eval`

## Requirements
- R1: On a rising `tck_i` edge with `ir_i` equal to 8'h01 and `shift_dr_i` high, `tdi_i` enters bit 7 of the challenge and every other bit moves one place toward bit 0; `challenge_o` shows the register at all times.
- R2: On a rising `tck_i` edge where `ir_i` is not 8'h01 or `shift_dr_i` is low, the challenge register is unchanged.
- R3: Challenge bits [3:0] select the oscillator line counted by A and bits [7:4] the line counted by B. Both are taken when start is accepted, and shifting during a measurement does not change them.
- R4: Each rising edge of a selected line (high and low each held at least two system clock cycles) that falls inside the window adds exactly one to its counter; edges on unselected lines add nothing.
- R5: With start accepted at clock edge t0, `done_o` is high for exactly one cycle, after edge t0+W, where W is `window_i` sampled at t0; a `window_i` of 0 acts as 1.
- R6: Accepting start clears both counts. After done, both counts stay unchanged until the next accepted start.
- R7: `response_o` is 1 when `count_a_o` is greater than `count_b_o`, and 0 when the counts are equal or when B is greater.
- R8: A counter that reaches 2^CNT_W-1 stays at that value and does not wrap.
- R9: A start request while measuring or during the done cycle is ignored: it produces no extra done and changes neither the counts nor the window timing.
- R10: After reset, the challenge, both counts, `done_o` and `response_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tck_i | input | 1 | Shift clock for the challenge register |
| tdi_i | input | 1 | Serial challenge data |
| shift_dr_i | input | 1 | Shift enable from the access port |
| ir_i | input | IR_W | Current instruction; 8'h01 enables loading |
| osc_i | input | NUM_OSC | Asynchronous oscillator lines |
| start_i | input | 1 | Measurement start request |
| window_i | input | WIN_W | Window length in system clock cycles |
| challenge_o | output | 2*SEL_W | Parallel view of the challenge register |
| response_o | output | 1 | Response bit, A count greater than B count |
| done_o | output | 1 | One-cycle pulse at the end of the window |
| count_a_o | output | CNT_W | Edge count of the line chosen by bits [3:0] |
| count_b_o | output | CNT_W | Edge count of the line chosen by bits [7:4] |

## Verification
Two of this block's functions can fall in the same cycle. The first is the close of a window, which is the done cycle. The second is the acceptance of a new start request. The bench raises `start_i` exactly while `done_o` is high. It then judges the result: no second done may appear over a full window plus margin, and both counts must stay frozen. A start raised in the middle of a run is judged the same way, against the unchanged done timing. A separate case shifts a new challenge in during a run while pulsing both the old and the new lines. Only the old pair may be counted.

// File: rtl/puf_pkg.sv
package puf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } meas_state_e;
endpackage

// File: rtl/puf_chal_shift.sv
module puf_chal_shift #(
  parameter int                CHAL_W  = 8,
  parameter int                IR_W    = 8,
  parameter logic [IR_W-1:0]   IR_LOAD = 8'h01
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  logic              shift_dr_i,
  input  logic [IR_W-1:0]   ir_i,
  output logic [CHAL_W-1:0] chal_o
);
  logic [CHAL_W-1:0] chal_q;
  logic              shift_en;

  assign shift_en = shift_dr_i && (ir_i == IR_LOAD);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       chal_q <= '0;
    else if (shift_en) chal_q <= {tdi_i, chal_q[CHAL_W-1:1]};
  end

  assign chal_o = chal_q;

  AST_SHIFT_IN: assert property (@(posedge tck_i) disable iff (!rst_ni)
    shift_en |=> (chal_q[CHAL_W-1] == $past(tdi_i))); // R1
  AST_NO_SHIFT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !shift_en |=> $stable(chal_q)); // R2
endmodule

// File: rtl/puf_edge_det.sv
module puf_edge_det #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    // [0],[1] synchroniser, [2] previous value
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], line_i[i]};
    end
    assign rise_o[i] = sh_q[1] & ~sh_q[2];

    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]); // R4
  end
endmodule

// File: rtl/puf_sat_cnt.sv
module puf_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> (cnt_q == MAX)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/puf_ctrl.sv
module puf_ctrl
  import puf_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int WIN_W  = 16,
  localparam int CHAL_W = 2 * SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAL_W-1:0] chal_i,
  input  logic              start_i,
  input  logic [WIN_W-1:0]  window_i,
  output logic [SEL_W-1:0]  sel_a_o,
  output logic [SEL_W-1:0]  sel_b_o,
  output logic              clr_o,
  output logic              run_o,
  output logic              done_o
);
  meas_state_e       state_q;
  logic [CHAL_W-1:0] chal_m_q, chal_s_q, sel_q;
  logic [WIN_W-1:0]  win_q, wcnt_q;
  logic              start_ok;

  // challenge is quasi-static: held stable for several cycles before start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chal_m_q <= '0;
      chal_s_q <= '0;
    end else begin
      chal_m_q <= chal_i;
      chal_s_q <= chal_m_q;
    end
  end

  assign start_ok = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      win_q   <= '0;
      wcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          sel_q   <= chal_s_q;
          win_q   <= (window_i == '0) ? WIN_W'(1) : window_i;
          wcnt_q  <= WIN_W'(1);
        end
        ST_RUN: begin
          if (wcnt_q == win_q) state_q <= ST_FIN;
          else                 wcnt_q  <= wcnt_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_a_o = sel_q[SEL_W-1:0];
  assign sel_b_o = sel_q[CHAL_W-1:SEL_W];
  assign clr_o   = start_ok;
  assign run_o   = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_FIN);

  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> $stable(sel_q)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_IDLE) |=> ($stable(win_q) && $stable(sel_q))); // R9
  AST_NO_DONE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == ST_IDLE)); // R9
endmodule

// File: rtl/ro_puf_eval.sv
module ro_puf_eval #(
  parameter int              NUM_OSC = 16,
  parameter int              CNT_W   = 16,
  parameter int              WIN_W   = 16,
  parameter int              IR_W    = 8,
  parameter logic [IR_W-1:0] IR_LOAD = 8'h01,
  localparam int             SEL_W   = $clog2(NUM_OSC),
  localparam int             CHAL_W  = 2 * SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tck_i,
  input  logic               tdi_i,
  input  logic               shift_dr_i,
  input  logic [IR_W-1:0]    ir_i,
  input  logic [NUM_OSC-1:0] osc_i,
  input  logic               start_i,
  input  logic [WIN_W-1:0]   window_i,
  output logic [CHAL_W-1:0]  challenge_o,
  output logic               response_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   count_a_o,
  output logic [CNT_W-1:0]   count_b_o
);
  logic [NUM_OSC-1:0] rise;
  logic [SEL_W-1:0]   sel_a, sel_b;
  logic               clr, run;

  puf_chal_shift #(.CHAL_W(CHAL_W), .IR_W(IR_W), .IR_LOAD(IR_LOAD)) i_chal (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .tdi_i      (tdi_i),
    .shift_dr_i (shift_dr_i),
    .ir_i       (ir_i),
    .chal_o     (challenge_o)
  );

  puf_edge_det #(.N(NUM_OSC)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (osc_i),
    .rise_o (rise)
  );

  puf_ctrl #(.SEL_W(SEL_W), .WIN_W(WIN_W)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .chal_i   (challenge_o),
    .start_i  (start_i),
    .window_i (window_i),
    .sel_a_o  (sel_a),
    .sel_b_o  (sel_b),
    .clr_o    (clr),
    .run_o    (run),
    .done_o   (done_o)
  );

  puf_sat_cnt #(.W(CNT_W)) i_cnt_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (run && rise[sel_a]),
    .cnt_o  (count_a_o)
  );

  puf_sat_cnt #(.W(CNT_W)) i_cnt_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (run && rise[sel_b]),
    .cnt_o  (count_b_o)
  );

  assign response_o = (count_a_o > count_b_o);

  AST_COUNT_ONLY_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !clr) |=> ($stable(count_a_o) && $stable(count_b_o))); // R6
endmodule

// File: tb/test_ro_puf_eval.sv
module test_ro_puf_eval;
  localparam int CNT_W = 8;
  localparam int WIN_W = 12;

  logic             clk_i = 0, rst_ni = 0, tck_i = 0, tdi_i = 0, shift_dr_i = 0;
  logic [7:0]       ir_i = 0;
  logic [15:0]      osc_i = 0;
  logic             start_i = 0;
  logic [WIN_W-1:0] window_i = 0;
  logic [7:0]       challenge_o;
  logic             response_o, done_o;
  logic [CNT_W-1:0] count_a_o, count_b_o;

  int n_chk = 0, n_err = 0;

  always #2 clk_i = ~clk_i;

  ro_puf_eval #(.CNT_W(CNT_W), .WIN_W(WIN_W)) i_ro_puf_eval (.*);

  typedef struct packed {
    logic [7:0] chal;
    int         win;
    int         na;
    int         nb;
    int         ea;
    int         eb;
    logic       resp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'h21, 100, 5, 3, 5, 3, 1'b1},
    '{8'h7C, 120, 4, 9, 4, 9, 1'b0},
    '{8'h55,  60, 6, 6, 6, 6, 1'b0},
    '{8'hF0,  40, 0, 2, 0, 2, 1'b0},
    '{8'h0F,  80, 7, 0, 7, 0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, input logic [7:0] ir, input logic sdr);
    ir_i = ir; shift_dr_i = sdr; tdi_i = b;
    #10 tck_i = 1;
    #10 tck_i = 0;
  endtask

  task automatic load_chal(input logic [7:0] v);
    for (int i = 0; i < 8; i++) shift_bit(v[i], 8'h01, 1'b1);
    shift_dr_i = 0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic pulse(input int a, input int na, input int b, input int nb);
    int m;
    m = (na > nb) ? na : nb;
    for (int k = 0; k < m; k++) begin
      @(negedge clk_i);
      if (k < na) osc_i[a] = 1'b1;
      if (k < nb) osc_i[b] = 1'b1;
      repeat (2) @(negedge clk_i);
      osc_i = '0;
      @(negedge clk_i);
    end
  endtask

  task automatic do_start(input int w);
    @(negedge clk_i);
    window_i = WIN_W'(w);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (n < 5000) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (done_o) break;
    end
  endtask

  task automatic check_result(input string req, input int n, input int w,
                              input int ea, input int eb, input logic er);
    chk(n == w, {req, " R5 window"}, n, w);
    chk(int'(count_a_o) == ea, {req, " R4 count A"}, count_a_o, ea);
    chk(int'(count_b_o) == eb, {req, " R4 count B"}, count_b_o, eb);
    chk(response_o == er, {req, " R7 response"}, response_o, er);
  endtask

  initial begin
    #1_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic [CNT_W-1:0] ha, hb;
    bit   seen;
    repeat (3) @(negedge clk_i);
    chk(challenge_o == 0, "R10 challenge", challenge_o, 0);
    chk(count_a_o == 0 && count_b_o == 0, "R10 counts", count_a_o, 0);
    chk(done_o == 0 && response_o == 0, "R10 done/resp", done_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // R1 load then one extra shift
    load_chal(8'hA5);
    chk(challenge_o == 8'hA5, "R1 load", challenge_o, 8'hA5);
    shift_bit(1'b0, 8'h01, 1'b1);
    chk(challenge_o == 8'h52, "R1 shift toward bit0", challenge_o, 8'h52);
    // R2 wrong instruction / shift-dr low
    for (int i = 0; i < 3; i++) shift_bit(1'b1, 8'h02, 1'b1);
    chk(challenge_o == 8'h52, "R2 wrong ir", challenge_o, 8'h52);
    for (int i = 0; i < 3; i++) shift_bit(1'b1, 8'h01, 1'b0);
    chk(challenge_o == 8'h52, "R2 shift_dr low", challenge_o, 8'h52);

    // table of measurements (R3 R4 R5 R7)
    for (int v = 0; v < 5; v++) begin
      load_chal(VECS[v].chal);
      do_start(VECS[v].win);
      fork
        begin
          repeat (2) @(negedge clk_i);
          pulse(int'(VECS[v].chal[3:0]), VECS[v].na, int'(VECS[v].chal[7:4]), VECS[v].nb);
        end
        wait_done(n);
      join
      check_result($sformatf("vec%0d R3", v), n, VECS[v].win, VECS[v].ea, VECS[v].eb, VECS[v].resp);
      @(negedge clk_i);
      chk(done_o == 0, "R5 one-cycle done", done_o, 0);
    end

    // R6 hold after done
    ha = count_a_o; hb = count_b_o;
    repeat (20) @(negedge clk_i);
    chk(count_a_o == ha && count_b_o == hb, "R6 counts held", count_a_o, ha);

    // R5 window 0 acts as 1; R6 clear on start
    do_start(0);
    wait_done(n);
    chk(n == 1, "R5 window zero", n, 1);
    chk(count_a_o == 0 && count_b_o == 0, "R6 cleared on start", count_a_o, 0);

    // R8 saturation
    load_chal(8'h32);
    do_start(1400);
    fork
      begin repeat (2) @(negedge clk_i); pulse(2, 300, 3, 10); end
      wait_done(n);
    join
    check_result("R8 saturation", n, 1400, 255, 10, 1'b1);

    // R3 new challenge during run does not move selection
    load_chal(8'h21);
    do_start(200);
    fork
      begin
        for (int i = 0; i < 8; i++) shift_bit(8'h43 >> i, 8'h01, 1'b1);
        shift_dr_i = 0;
        pulse(1, 4, 2, 2);
        pulse(3, 5, 4, 5);
      end
      wait_done(n);
    join
    check_result("R3 held selection", n, 200, 4, 2, 1'b1);
    chk(challenge_o == 8'h43, "R1 shifted during run", challenge_o, 8'h43);

    // R9 start mid-run, then start on the done cycle
    load_chal(8'h21);
    do_start(50);
    fork
      begin
        repeat (10) @(negedge clk_i); start_i = 1;
        @(negedge clk_i); start_i = 0;
      end
      begin repeat (2) @(negedge clk_i); pulse(1, 3, 2, 1); end
      wait_done(n);
    join
    check_result("R9 start mid-run", n, 50, 3, 1, 1'b1);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      if (done_o) seen = 1;
      @(negedge clk_i);
    end
    chk(!seen, "R9 start on done cycle", seen, 0);
    chk(count_a_o == 3 && count_b_o == 1, "R9 counts kept", count_a_o, 3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule